// File: doc/BRIEF.md
# Transmitter Equalization Coefficient Legality Checker

This block screens a requested set of transmitter equalization coefficients before the set reaches the local line driver. A request carries three cursor values packed into one word: pre-cursor magnitude, main cursor and post-cursor magnitude. The block unpacks the word and tests it against two programmable limits, a full-swing value and a low-frequency value. It returns a registered verdict and a vector that names each rule that was broken.

Only a set that passes every rule is copied into the applied-coefficient register. That register drives the transmitter and also supplies the values advertised to the link partner. A rejected request leaves the register as it was. Both limits sit in registers that software or training logic can reload, and they come up from reset at fixed default values.

Top module: `txeq_coef_checker`

## Requirements
- R1: After reset the full-swing limit is 60 and the low-frequency limit is 20. The applied word holds main cursor 60 with pre-cursor and post-cursor both 0, which is 18'h00F00. `chk_valid`, `chk_legal` and `chk_fail` are all 0.
- R2: `req_word` carries the pre-cursor magnitude in bits [5:0], the main cursor in bits [11:6] and the post-cursor magnitude in bits [17:12]. All three are unsigned. `appl_word` uses the same layout.
- R3: Rule A is reported on `chk_fail[0]`. It fails when the pre-cursor exceeds floor(FS/4), where FS is the current full-swing limit. With FS = 60 a pre-cursor of 15 passes and 16 fails.
- R4: Rule B is reported on `chk_fail[1]`. It fails unless pre-cursor plus main cursor plus post-cursor equals FS exactly.
- R5: Rule C is reported on `chk_fail[2]`. It fails when the main cursor minus the pre-cursor minus the post-cursor is below LF, the current low-frequency limit. A difference equal to LF passes.
- R6: For a request accepted on a clock edge with `req_valid` high, `chk_valid` is high for exactly the following cycle. In that cycle `chk_legal` is 1 exactly when all three `chk_fail` bits are 0.
- R7: When a request is legal, `appl_word` takes the request word on the same edge that the verdict appears.
- R8: When a request is illegal, `appl_word` keeps its previous value.
- R9: With `lim_load` high on an edge, the limits take `lim_fs` and `lim_lf`. The new limits apply to requests on later edges. A request on that same edge is judged against the old limits.
- R10: On an edge with `req_valid` low, `chk_valid` goes low, while `chk_legal`, `chk_fail` and `appl_word` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_load | input | 1 | Load strobe for both limits |
| lim_fs | input | 6 | New full-swing limit |
| lim_lf | input | 6 | New low-frequency limit |
| req_valid | input | 1 | Request qualifier |
| req_word | input | 18 | Packed requested coefficients |
| chk_valid | output | 1 | Verdict strobe, one cycle after a request |
| chk_legal | output | 1 | Last verdict: all rules met |
| chk_fail | output | 3 | Last per-rule failure vector {C,B,A} |
| appl_word | output | 18 | Applied coefficients, packed |

## Verification
Hand-picked sets each break exactly one rule, so the position of every failure bit is checked on its own. Sets that sit exactly on a limit, such as pre-cursor equal to floor(FS/4) or main minus side cursors equal to LF, separate a strict comparison from an inclusive one. A set that breaks all three rules shows that the rules are independent. A limit reload issued on the same edge as a request tells apart which limits judge that request. Random word streams, some of them biased so they sum to FS, are then compared against a behavioural model on every cycle.

// File: rtl/txeq_pkg.sv
package txeq_pkg;
   localparam int unsigned RULE_N  = 3;
   localparam int unsigned RULE_PRE = 0;
   localparam int unsigned RULE_SUM = 1;
   localparam int unsigned RULE_EYE = 2;
   localparam int unsigned CURSOR_N = 3;
   typedef logic [RULE_N-1:0] rule_vec_t;
endpackage

// File: rtl/txeq_limits.sv
module txeq_limits #(
   parameter int unsigned LIMIT_W = 6,
   parameter int unsigned DEF_FS  = 60,
   parameter int unsigned DEF_LF  = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LIMIT_W-1:0] fs_in,
   input  logic [LIMIT_W-1:0] lf_in,
   output logic [LIMIT_W-1:0] fs_q,
   output logic [LIMIT_W-1:0] lf_q
);
   localparam logic [LIMIT_W-1:0] FS_RST = LIMIT_W'(DEF_FS);
   localparam logic [LIMIT_W-1:0] LF_RST = LIMIT_W'(DEF_LF);

   initial begin
      assert (DEF_FS < (1 << LIMIT_W)) else $error("DEF_FS does not fit LIMIT_W");
      assert (DEF_LF < (1 << LIMIT_W)) else $error("DEF_LF does not fit LIMIT_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q <= FS_RST;
         lf_q <= LF_RST;
      end else if (load) begin
         fs_q <= fs_in;
         lf_q <= lf_in;
      end
   end

   assert_limit_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (fs_q == $past(fs_in)) && (lf_q == $past(lf_in)));
endmodule

// File: rtl/txeq_unpack.sv
module txeq_unpack #(
   parameter int unsigned FIELD_W = 6,
   localparam int unsigned WORD_W = 3 * FIELD_W
) (
   input  logic [WORD_W-1:0]  word,
   output logic [FIELD_W-1:0] pre,
   output logic [FIELD_W-1:0] main,
   output logic [FIELD_W-1:0] post
);
   logic [FIELD_W-1:0] fld [txeq_pkg::CURSOR_N];

   // R2: fields low to high are pre, main, post
   for (genvar i = 0; i < int'(txeq_pkg::CURSOR_N); i++) begin : g_fld
      assign fld[i] = word[i*FIELD_W +: FIELD_W];
   end

   assign pre  = fld[0];
   assign main = fld[1];
   assign post = fld[2];
endmodule

// File: rtl/txeq_rules.sv
module txeq_rules #(
   parameter int unsigned FIELD_W = 6,
   parameter int unsigned LIMIT_W = 6
) (
   input  logic [FIELD_W-1:0]  pre,
   input  logic [FIELD_W-1:0]  main,
   input  logic [FIELD_W-1:0]  post,
   input  logic [LIMIT_W-1:0]  fs,
   input  logic [LIMIT_W-1:0]  lf,
   output txeq_pkg::rule_vec_t fail
);
   localparam int unsigned BASE_W = (FIELD_W > LIMIT_W) ? FIELD_W : LIMIT_W;
   localparam int unsigned SUM_W  = BASE_W + 2;

   logic [SUM_W-1:0] quarter, total, floor_need, pre_x, main_x, post_x, fs_x, lf_x;

   always_comb begin
      pre_x      = SUM_W'(pre);
      main_x     = SUM_W'(main);
      post_x     = SUM_W'(post);
      fs_x       = SUM_W'(fs);
      lf_x       = SUM_W'(lf);
      quarter    = fs_x >> 2;                 // floor(FS/4), no divider
      total      = pre_x + main_x + post_x;
      floor_need = pre_x + post_x + lf_x;     // main - pre - post >= lf rearranged
      fail                      = '0;
      fail[txeq_pkg::RULE_PRE]  = pre_x > quarter;      // R3
      fail[txeq_pkg::RULE_SUM]  = total != fs_x;        // R4
      fail[txeq_pkg::RULE_EYE]  = main_x < floor_need;  // R5
   end
endmodule

// File: rtl/txeq_hold.sv
module txeq_hold #(
   parameter int unsigned           WORD_W   = 18,
   parameter logic [WORD_W-1:0]     RST_WORD = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [WORD_W-1:0]   req_word,
   input  txeq_pkg::rule_vec_t fail,
   output logic                chk_valid,
   output logic                chk_legal,
   output txeq_pkg::rule_vec_t chk_fail,
   output logic [WORD_W-1:0]   appl_word
);
   logic pass;
   assign pass = ~|fail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_valid <= 1'b0;
         chk_legal <= 1'b0;
         chk_fail  <= '0;
         appl_word <= RST_WORD;
      end else begin
         chk_valid <= req_valid;
         if (req_valid) begin
            chk_legal <= pass;
            chk_fail  <= fail;
            if (pass) appl_word <= req_word;
         end
      end
   end

   assert_verdict_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> chk_valid);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !chk_valid && $stable(appl_word) && $stable(chk_fail));
   assert_legal_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && chk_legal |-> appl_word == $past(req_word));
   assert_reject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && !chk_legal |-> $stable(appl_word));
   assert_fail_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> (chk_legal != (|chk_fail)));
endmodule

// File: rtl/txeq_coef_checker.sv
module txeq_coef_checker #(
   parameter int unsigned FIELD_W = 6,
   parameter int unsigned LIMIT_W = 6,
   parameter int unsigned DEF_FS  = 60,
   parameter int unsigned DEF_LF  = 20,
   localparam int unsigned WORD_W = 3 * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lim_load,
   input  logic [LIMIT_W-1:0] lim_fs,
   input  logic [LIMIT_W-1:0] lim_lf,
   input  logic               req_valid,
   input  logic [WORD_W-1:0]  req_word,
   output logic               chk_valid,
   output logic               chk_legal,
   output logic [2:0]         chk_fail,
   output logic [WORD_W-1:0]  appl_word
);
   // R1: reset set is main = FS, side cursors zero
   localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(DEF_FS) << FIELD_W;

   initial begin
      assert (FIELD_W >= 2) else $error("FIELD_W too small");
      assert (DEF_FS < (1 << FIELD_W)) else $error("DEF_FS does not fit a cursor field");
   end

   logic [LIMIT_W-1:0]  fs_q, lf_q;
   logic [FIELD_W-1:0]  c_pre, c_main, c_post;
   txeq_pkg::rule_vec_t fail_now, fail_q;

   txeq_limits #(.LIMIT_W(LIMIT_W), .DEF_FS(DEF_FS), .DEF_LF(DEF_LF)) u_limits (
      .clk(clk), .rst_n(rst_n), .load(lim_load), .fs_in(lim_fs), .lf_in(lim_lf),
      .fs_q(fs_q), .lf_q(lf_q));

   txeq_unpack #(.FIELD_W(FIELD_W)) u_unpack (
      .word(req_word), .pre(c_pre), .main(c_main), .post(c_post));

   txeq_rules #(.FIELD_W(FIELD_W), .LIMIT_W(LIMIT_W)) u_rules (
      .pre(c_pre), .main(c_main), .post(c_post), .fs(fs_q), .lf(lf_q), .fail(fail_now));

   txeq_hold #(.WORD_W(WORD_W), .RST_WORD(RST_WORD)) u_hold (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .fail(fail_now), .chk_valid(chk_valid), .chk_legal(chk_legal),
      .chk_fail(fail_q), .appl_word(appl_word));

   assign chk_fail = fail_q;
endmodule

// File: tb/txeq_coef_checker_bench.sv
module txeq_coef_checker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lim_load = 1'b0;
   logic [5:0]  lim_fs = '0, lim_lf = '0;
   logic        req_valid = 1'b0;
   logic [17:0] req_word = '0;
   logic        chk_valid, chk_legal;
   logic [2:0]  chk_fail;
   logic [17:0] appl_word;

   int n_chk = 0, n_bad = 0;
   int m_fs = 60, m_lf = 20, m_app = 60 << 6, m_fail = 0;
   bit m_valid = 0, m_legal = 0;

   always #2 clk = ~clk;   // 250 MHz

   txeq_coef_checker u_txeq_coef_checker (
      .clk(clk), .rst_n(rst_n), .lim_load(lim_load), .lim_fs(lim_fs), .lim_lf(lim_lf),
      .req_valid(req_valid), .req_word(req_word), .chk_valid(chk_valid),
      .chk_legal(chk_legal), .chk_fail(chk_fail), .appl_word(appl_word));

   task automatic compare(input string tag);
      n_chk++;
      if (chk_valid !== m_valid || chk_legal !== m_legal || chk_fail !== 3'(m_fail)
          || appl_word !== 18'(m_app)) begin
         n_bad++;
         $display("FAIL %s: got v=%0b l=%0b f=%03b w=%05h expected v=%0b l=%0b f=%03b w=%05h",
                  tag, chk_valid, chk_legal, chk_fail, appl_word,
                  m_valid, m_legal, 3'(m_fail), 18'(m_app));
      end
   endtask

   // Called at a negedge: drive, model the edge, compare at the next negedge.
   task automatic step(input string tag, input bit ld, input int fs, input int lf,
                       input bit v, input int pre, input int main, input int post);
      lim_load  = ld;
      lim_fs    = 6'(fs);
      lim_lf    = 6'(lf);
      req_valid = v;
      req_word  = {6'(post), 6'(main), 6'(pre)};
      @(posedge clk);
      if (v) begin
         m_fail = 0;
         if (pre > m_fs / 4)                m_fail |= 1;
         if (pre + main + post != m_fs)     m_fail |= 2;
         if (main - pre - post < m_lf)      m_fail |= 4;
         m_valid = 1;
         m_legal = (m_fail == 0);
         if (m_legal) m_app = (post << 12) | (main << 6) | pre;
      end else begin
         m_valid = 0;
      end
      if (ld) begin
         m_fs = fs;
         m_lf = lf;
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset state");
      rst_n = 1'b1;
      step("R1 idle after reset", 0, 0, 0, 0, 0, 0, 0);
      step("R1 default set legal", 0, 0, 0, 1, 0, 60, 0);
      step("R3 R5 boundary legal", 0, 0, 0, 1, 15, 40, 5);
      step("R3 pre 16 fails", 0, 0, 0, 1, 16, 44, 0);
      step("R8 illegal keeps applied", 0, 0, 0, 0, 0, 0, 0);
      step("R4 sum 59 fails", 0, 0, 0, 1, 0, 59, 0);
      step("R4 sum 61 fails", 0, 0, 0, 1, 0, 61, 0);
      step("R5 eye 10 fails", 0, 0, 0, 1, 10, 35, 15);
      step("R6 all rules fail", 0, 0, 0, 1, 16, 30, 0);
      step("R10 idle holds verdict", 0, 0, 0, 0, 1, 1, 1);
      step("R2 post only legal", 0, 0, 0, 1, 0, 45, 15);
      step("R7 capture", 0, 0, 0, 1, 5, 50, 5);
      // R9: load on same edge as a request; request uses old limits
      step("R9 same edge old limits", 1, 48, 12, 1, 0, 60, 0);
      step("R9 new FS 48 legal", 0, 0, 0, 1, 12, 30, 6);
      step("R9 new quarter 12, pre 13 fails", 0, 0, 0, 1, 13, 29, 6);
      step("R9 old default now fails", 0, 0, 0, 1, 0, 60, 0);
      step("R9 restore defaults", 1, 60, 20, 0, 0, 0, 0);
      step("R5 eye equal LF legal", 0, 0, 0, 1, 10, 40, 10);
      for (int i = 0; i < 400; i++) begin
         int p, m, q;
         p = $urandom_range(0, 63);
         m = $urandom_range(0, 63);
         q = $urandom_range(0, 63);
         if (i % 2 == 0) begin
            p = $urandom_range(0, 17);
            q = $urandom_range(0, 22);
            m = 60 - p - q;
            if (m < 0) m = 0;
         end
         step("R2 random stream", (i % 97) == 50, 60, $urandom_range(10, 25),
              (i % 5) != 4, p, m, q);
      end
      disable watchdog;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule